// File: doc/BRIEF.md
# Pin-Change and External Interrupt Controller

This peripheral watches input pins and raises interrupt requests toward a CPU. It has two kinds of source. One dedicated external pin has a two-bit sense field that selects one of four modes: low level, any change, falling edge or rising edge. In the three edge modes a qualifying transition sets a sticky flag. In low-level mode there is no flag, and the request follows the pin directly while the pin is low.

Up to 31 further pins are watched for toggles. They are split into four groups of eight pins, and the last group has only seven. Each pin has its own mask bit and each group has an enable bit. A toggle on a pin whose mask bit and group enable are both set marks that group's sticky flag.

Every pin passes through a two-flop synchronizer before detection. Software reads and writes the configuration, the enables, the masks and the flags over a simple byte-wide register bus. The CPU sees one request line and the index of the highest-priority pending source. It pulses an acknowledge when it enters that source's routine, and the acknowledge clears that source's flag.

Top module: `pinwatch_irq`

## Requirements
- R1: After reset, every mask, enable, flag and the sense field read zero, and `irqReq` is low.
- R2: A pin change is seen only after two synchronizer flops. A toggle driven between clock edges shows in the flag register after the third rising edge and not after the second.
- R3: The sense field sits in bits [1:0] of the register at address 0x69. The codes are: 01 any change, 10 falling edge, 11 rising edge. In these modes a matching transition of `extPin` sets the external flag, and a transition of the other direction leaves it clear.
- R4: With sense code 00 (low level), the external flag reads zero. The external request is asserted while the synchronized `extPin` is low, with `gie` and the external enable set, and it drops once the pin is high again.
- R5: The external source requests only when `gie` is high and the external enable is set. The external enable is bit 0 of the enable register at address 0x3D.
- R6: The flag register sits at address 0x3C: bit 0 is the external flag and bit g+1 is the flag of group g. Writing a one to a flag bit clears it. Writing a zero leaves it unchanged.
- R7: A pin toggle sets its group's flag only when the pin's mask bit is set and the group's enable is set. The group enable is bit g+1 of the register at 0x3D. A group requests only while its flag and its enable are both set.
- R8: The mask registers of groups 0 to 3 sit at addresses 0x6B, 0x6C, 0x6D and 0x73. Group g covers pins 8g+7 down to 8g, with mask bit b for pin 8g+b. Group 3 covers only pins 30 to 24, and its mask bit 7 always reads zero.
- R9: `irqSel` gives the pending source with the lowest index: 0 is the external source and g+1 is group g. A one-cycle `ackIn` pulse clears only the flag of that source. An acknowledge that arrives with no request pending changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 8 | Register address |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| extPin | input | 1 | Dedicated external interrupt pin |
| pinIn | input | 31 | Pin-change inputs |
| gie | input | 1 | Global interrupt enable from the CPU |
| ackIn | input | 1 | Acknowledge pulse from the CPU |
| irqReq | output | 1 | Any source requesting |
| irqSel | output | 3 | Index of the highest-priority pending source |

## Verification
A table of pin-change vectors varies four things: the group, the mask byte, the group enable, and the pin that toggles. This separates a hit from a masked pin, from a disabled group, and from a pin that belongs to a neighbouring group; it also covers the short last group. Each edge mode of the external pin is driven with both transition directions, so a mode that reacts to the wrong edge is caught. A directed sequence fills three flags at once and acknowledges them one at a time, which exposes a wrong priority order and any acknowledge that clears more than the served source. A toggle sampled after two edges and again after three pins down the synchronizer depth.

// File: rtl/pinwatch_pkg.sv
package pinwatch_pkg;
  localparam int NUM_PINS   = 31;
  localparam int GROUP_W    = 8;
  localparam int NUM_GROUPS = 4;
  localparam int BUS_W      = 8;
  localparam int NUM_SRC    = NUM_GROUPS + 1;
  localparam int SEL_W      = $clog2(NUM_SRC);
  localparam int GIDX_W     = $clog2(NUM_GROUPS);
  localparam int PAD_W      = NUM_GROUPS * GROUP_W;

  localparam logic [1:0] SENSE_LOW  = 2'b00;
  localparam logic [1:0] SENSE_ANY  = 2'b01;
  localparam logic [1:0] SENSE_FALL = 2'b10;
  localparam logic [1:0] SENSE_RISE = 2'b11;

  localparam logic [BUS_W-1:0] ADDR_CFG  = 8'h69;
  localparam logic [BUS_W-1:0] ADDR_ENA  = 8'h3D;
  localparam logic [BUS_W-1:0] ADDR_FLAG = 8'h3C;
  localparam logic [BUS_W-1:0] MASK_ADDR [NUM_GROUPS] = '{8'h6B, 8'h6C, 8'h6D, 8'h73};

  typedef enum logic [2:0] {RD_NONE, RD_CFG, RD_ENA, RD_FLAG, RD_MASK} rdsel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic                  wrCfg;
    logic                  wrEna;
    logic                  wrFlag;
    logic [NUM_GROUPS-1:0] wrMask;
    logic [NUM_SRC-1:0]    ackClr;
  } strobe_t;

  // Mask bits that map onto an existing pin
  function automatic logic [GROUP_W-1:0] validBits(input int g);
    logic [GROUP_W-1:0] v;
    for (int b = 0; b < GROUP_W; b++) v[b] = (g * GROUP_W + b) < NUM_PINS;
    return v;
  endfunction
endpackage

// File: rtl/pinwatch_ctl.sv
module pinwatch_ctl
  import pinwatch_pkg::*;
(
  input  logic               busWr,
  input  logic [BUS_W-1:0]   busAddr,
  input  logic               ackIn,
  input  logic [NUM_SRC-1:0] reqVec,
  output strobe_t            strb,
  output rdsel_t             rdSel,
  output logic [GIDX_W-1:0]  rdGrp,
  output logic               irqReq,
  output logic [SEL_W-1:0]   irqSel
);
  logic [SEL_W-1:0] selIdx;

  assign irqReq = |reqVec;
  assign irqSel = selIdx;

  // Fixed priority: lowest index wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (reqVec[i]) selIdx = SEL_W'(i);
  end

  always_comb begin
    strb  = '0;
    rdSel = RD_NONE;
    rdGrp = '0;
    if (busAddr == ADDR_CFG) begin
      rdSel      = RD_CFG;
      strb.wrCfg = busWr;
    end
    if (busAddr == ADDR_ENA) begin
      rdSel      = RD_ENA;
      strb.wrEna = busWr;
    end
    if (busAddr == ADDR_FLAG) begin
      rdSel       = RD_FLAG;
      strb.wrFlag = busWr;
    end
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (busAddr == MASK_ADDR[g]) begin
        rdSel          = RD_MASK;
        rdGrp          = GIDX_W'(g);
        strb.wrMask[g] = busWr;
      end
    end
    strb.ackClr = (ackIn && irqReq) ? (NUM_SRC'(1) << selIdx) : '0;
  end
endmodule

// File: rtl/pinwatch_dp.sv
module pinwatch_dp
  import pinwatch_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                extPin,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                gie,
  input  logic [BUS_W-1:0]    wrData,
  input  strobe_t             strb,
  input  rdsel_t              rdSel,
  input  logic [GIDX_W-1:0]   rdGrp,
  output logic [NUM_SRC-1:0]  reqVec,
  output logic [NUM_SRC-1:0]  flagQ,
  output logic [1:0]          senseQ,
  output logic [BUS_W-1:0]    rdData
);
  logic [PAD_W-1:0]   pinPad, syncA, syncB, syncC, pinToggle;
  logic               extA, extB, extC, extEvent, extFlag, extVis, extClr;
  logic [1:0]         senseReg;
  logic [NUM_SRC-1:0] enaReg;
  logic [GROUP_W-1:0] maskReg [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] grpFlag, grpHit, grpClr;

  assign pinPad = PAD_W'(pinIn);

  // Two synchronizer stages plus one history stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0; syncB <= '0; syncC <= '0;
      extA  <= 1'b0; extB <= 1'b0; extC <= 1'b0;
    end else begin
      syncA <= pinPad; syncB <= syncA; syncC <= syncB;
      extA  <= extPin; extB  <= extA;  extC  <= extB;
    end
  end

  assign pinToggle = syncB ^ syncC;

  always_comb begin
    unique case (senseReg)
      SENSE_ANY:  extEvent = extB ^ extC;
      SENSE_FALL: extEvent = extC & ~extB;
      SENSE_RISE: extEvent = ~extC & extB;
      default:    extEvent = 1'b0;
    endcase
  end

  assign extClr = strb.ackClr[0] | (strb.wrFlag & wrData[0]);
  assign extVis = extFlag & (senseReg != SENSE_LOW);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseReg <= SENSE_LOW;
      enaReg   <= '0;
      extFlag  <= 1'b0;
    end else begin
      if (strb.wrCfg) senseReg <= wrData[1:0];
      if (strb.wrEna) enaReg   <= wrData[NUM_SRC-1:0];
      if (senseReg == SENSE_LOW) extFlag <= 1'b0;
      else if (extEvent)         extFlag <= 1'b1;
      else if (extClr)           extFlag <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGrp
    assign grpHit[g] = enaReg[g+1] & (|(pinToggle[g*GROUP_W +: GROUP_W] & maskReg[g]));
    assign grpClr[g] = strb.ackClr[g+1] | (strb.wrFlag & wrData[g+1]);
    assign reqVec[g+1] = gie & enaReg[g+1] & grpFlag[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grpFlag <= '0;
      for (int g = 0; g < NUM_GROUPS; g++) maskReg[g] <= '0;
    end else begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (strb.wrMask[g]) maskReg[g] <= wrData[GROUP_W-1:0] & validBits(g);
        if (grpHit[g])      grpFlag[g] <= 1'b1;
        else if (grpClr[g]) grpFlag[g] <= 1'b0;
      end
    end
  end

  assign reqVec[0] = gie & enaReg[0] & ((senseReg == SENSE_LOW) ? ~extB : extVis);
  assign flagQ     = {grpFlag, extFlag};
  assign senseQ    = senseReg;

  always_comb begin
    unique case (rdSel)
      RD_CFG:  rdData = BUS_W'(senseReg);
      RD_ENA:  rdData = BUS_W'(enaReg);
      RD_FLAG: rdData = BUS_W'({grpFlag, extVis});
      RD_MASK: rdData = BUS_W'(maskReg[rdGrp]);
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/pinwatch_irq.sv
module pinwatch_irq
  import pinwatch_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic [BUS_W-1:0]    busAddr,
  input  logic [BUS_W-1:0]    busWrData,
  output logic [BUS_W-1:0]    busRdData,
  input  logic                extPin,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                gie,
  input  logic                ackIn,
  output logic                irqReq,
  output logic [SEL_W-1:0]    irqSel
);
  strobe_t            strb;
  rdsel_t             rdSel;
  logic [GIDX_W-1:0]  rdGrp;
  logic [NUM_SRC-1:0] reqVec, flagQ;
  logic [1:0]         senseQ;

  pinwatch_ctl u_ctl (
    .busWr(busWr), .busAddr(busAddr), .ackIn(ackIn), .reqVec(reqVec),
    .strb(strb), .rdSel(rdSel), .rdGrp(rdGrp), .irqReq(irqReq), .irqSel(irqSel)
  );

  pinwatch_dp u_dp (
    .clk(clk), .rstN(rstN), .extPin(extPin), .pinIn(pinIn), .gie(gie),
    .wrData(busWrData), .strb(strb), .rdSel(rdSel), .rdGrp(rdGrp),
    .reqVec(reqVec), .flagQ(flagQ), .senseQ(senseQ), .rdData(busRdData)
  );
endmodule

// File: rtl/pinwatch_chk.sv
module pinwatch_chk
  import pinwatch_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               gie,
  input logic               irqReq,
  input logic [SEL_W-1:0]   irqSel,
  input logic [NUM_SRC-1:0] reqVec,
  input logic [NUM_SRC-1:0] flagQ,
  input logic [1:0]         senseQ,
  input logic [NUM_SRC-1:0] ackClr
);
  p_gie_gate_r5: assert property (@(posedge clk) disable iff (!rstN) !gie |-> !irqReq);

  p_level_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (senseQ == SENSE_LOW && $past(senseQ == SENSE_LOW)) |-> !flagQ[0]);

  p_ack_onehot_r9: assert property (@(posedge clk) disable iff (!rstN) $onehot0(ackClr));

  p_ack_needs_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ackClr != '0) |-> (irqReq && ackClr[irqSel]));

  p_sel_pending_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqSel != '0) |-> (!reqVec[0] && reqVec[irqSel]));

  p_grp_req_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqVec[NUM_SRC-1:1] & ~flagQ[NUM_SRC-1:1]) == '0);
endmodule

bind pinwatch_irq pinwatch_chk u_chk (
  .clk(clk), .rstN(rstN), .gie(gie), .irqReq(irqReq), .irqSel(irqSel),
  .reqVec(reqVec), .flagQ(flagQ), .senseQ(senseQ), .ackClr(strb.ackClr)
);

// File: tb/tb_pinwatch_irq.sv
module tb_pinwatch_irq;
  import pinwatch_pkg::*;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] grp;
    logic [7:0] mask;
    logic       en;
    logic [4:0] pin;
    logic       hit;
  } vec_t;
  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 8'h01, 1'b1, 5'd0,  1'b1},
    '{2'd0, 8'h02, 1'b1, 5'd0,  1'b0},
    '{2'd1, 8'hFF, 1'b0, 5'd9,  1'b0},
    '{2'd1, 8'h80, 1'b1, 5'd15, 1'b1},
    '{2'd2, 8'h10, 1'b1, 5'd20, 1'b1},
    '{2'd3, 8'h40, 1'b1, 5'd30, 1'b1},
    '{2'd3, 8'h01, 1'b1, 5'd24, 1'b1},
    '{2'd2, 8'h01, 1'b1, 5'd8,  1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0, busWr = 1'b0, extPin = 1'b1, gie = 1'b0, ackIn = 1'b0;
  logic [7:0] busAddr = '0, busWrData = '0, busRdData, d;
  logic [NUM_PINS-1:0] pinIn = '0;
  logic irqReq;
  logic [SEL_W-1:0] irqSel;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  pinwatch_irq dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWrData = v;
    @(negedge clk);
    busWr = 1'b0; busAddr = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    busAddr = a;
    #1 v = busRdData;
  endtask

  task automatic ack();
    @(negedge clk); ackIn = 1'b1;
    @(negedge clk); ackIn = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    ticks(3);
    rstN = 1'b1;
    ticks(2);
    // R1 reset state
    rd(ADDR_CFG, d);  check("R1 cfg", d, 0);
    rd(ADDR_ENA, d);  check("R1 ena", d, 0);
    rd(ADDR_FLAG, d); check("R1 flag", d, 0);
    for (int g = 0; g < NUM_GROUPS; g++) begin
      rd(MASK_ADDR[g], d); check($sformatf("R1 mask%0d", g), d, 0);
    end
    check("R1 irqReq", irqReq, 0);

    // R8 mask readback and group 3 top bit
    wr(MASK_ADDR[3], 8'hFF); rd(MASK_ADDR[3], d); check("R8 grp3 top bit", d, 8'h7F);
    wr(MASK_ADDR[0], 8'hA5); rd(MASK_ADDR[0], d); check("R8 grp0 readback", d, 8'hA5);
    wr(MASK_ADDR[3], 8'h00); wr(MASK_ADDR[0], 8'h00);

    // R7 R8 vector table
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      wr(MASK_ADDR[v.grp], v.mask);
      wr(ADDR_ENA, v.en ? 8'(1 << (int'(v.grp) + 1)) : 8'h00);
      pinIn[v.pin] = ~pinIn[v.pin];
      ticks(4);
      rd(ADDR_FLAG, d);
      check($sformatf("R7 R8 vec%0d", i), d, v.hit ? (1 << (int'(v.grp) + 1)) : 0);
      wr(ADDR_FLAG, 8'h1F); wr(MASK_ADDR[v.grp], 8'h00); wr(ADDR_ENA, 8'h00);
    end

    // R2 synchronizer latency
    wr(MASK_ADDR[1], 8'h04); wr(ADDR_ENA, 8'h04);
    pinIn[10] = ~pinIn[10];
    ticks(2); rd(ADDR_FLAG, d); check("R2 not after two edges", d, 0);
    ticks(1); rd(ADDR_FLAG, d); check("R2 set after three edges", d, 8'h04);
    wr(ADDR_FLAG, 8'h1F); wr(MASK_ADDR[1], 8'h00); wr(ADDR_ENA, 8'h00);

    // R3 rising mode, R6 write-one-clear
    wr(ADDR_CFG, {6'b0, SENSE_RISE});
    extPin = 1'b0; ticks(4); rd(ADDR_FLAG, d); check("R3 rise mode ignores fall", d, 0);
    extPin = 1'b1; ticks(4); rd(ADDR_FLAG, d); check("R3 rise mode sets", d, 1);
    wr(ADDR_FLAG, 8'h00); rd(ADDR_FLAG, d); check("R6 write zero keeps", d, 1);
    wr(ADDR_FLAG, 8'h01); rd(ADDR_FLAG, d); check("R6 write one clears", d, 0);
    // R3 falling mode
    wr(ADDR_CFG, {6'b0, SENSE_FALL});
    extPin = 1'b0; ticks(4); rd(ADDR_FLAG, d); check("R3 fall mode sets", d, 1);
    wr(ADDR_FLAG, 8'h01);
    extPin = 1'b1; ticks(4); rd(ADDR_FLAG, d); check("R3 fall mode ignores rise", d, 0);
    // R3 any-change mode
    wr(ADDR_CFG, {6'b0, SENSE_ANY});
    extPin = 1'b0; ticks(4); rd(ADDR_FLAG, d); check("R3 any mode fall", d, 1);
    wr(ADDR_FLAG, 8'h01);
    extPin = 1'b1; ticks(4); rd(ADDR_FLAG, d); check("R3 any mode rise", d, 1);

    // R5 gating with the external flag set
    wr(ADDR_ENA, 8'h01); gie = 1'b0; #1 check("R5 gie low blocks", irqReq, 0);
    wr(ADDR_ENA, 8'h00); gie = 1'b1; #1 check("R5 enable low blocks", irqReq, 0);
    wr(ADDR_ENA, 8'h01); #1 check("R5 request", irqReq, 1);
    check("R5 irqSel ext", irqSel, 0);

    // R4 level mode
    wr(ADDR_CFG, {6'b0, SENSE_LOW});
    rd(ADDR_FLAG, d); check("R4 flag reads zero", d, 0);
    check("R4 pin high no request", irqReq, 0);
    extPin = 1'b0; ticks(3); check("R4 pin low requests", irqReq, 1);
    rd(ADDR_FLAG, d); check("R4 flag stays zero", d, 0);
    extPin = 1'b1; ticks(3); check("R4 pin high drops", irqReq, 0);

    // R9 priority and acknowledge
    wr(ADDR_CFG, {6'b0, SENSE_RISE});
    extPin = 1'b0; ticks(4); extPin = 1'b1; ticks(4);
    wr(MASK_ADDR[0], 8'h01); wr(MASK_ADDR[2], 8'h01); wr(ADDR_ENA, 8'h0B);
    pinIn[0] = ~pinIn[0]; pinIn[16] = ~pinIn[16];
    ticks(4);
    rd(ADDR_FLAG, d); check("R9 three pending", d, 8'h0B);
    gie = 1'b0; ack(); rd(ADDR_FLAG, d); check("R9 ack without request ignored", d, 8'h0B);
    gie = 1'b1; #1 check("R9 sel ext first", irqSel, 0);
    ack(); rd(ADDR_FLAG, d); check("R9 ack clears ext only", d, 8'h0A);
    check("R9 sel group0", irqSel, 1);
    ack(); rd(ADDR_FLAG, d); check("R9 ack clears group0 only", d, 8'h08);
    check("R9 sel group2", irqSel, 3);
    ack(); rd(ADDR_FLAG, d); check("R9 all served", d, 0);
    check("R9 request low", irqReq, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule